// File: doc/BRIEF.md
# Hardware Monitor Alarm and Interrupt Logic

This block turns the readings of a hardware monitor into alarm flags and one active-low system management interrupt. It compares each voltage reading against its own window of low and high limits. It compares the temperature reading against a high limit, and a separate lower threshold clears that alarm. Every comparison is taken only when the sample-valid strobe is high, so readings that change between strobes have no effect.

Each fan is flagged as faulty only after a qualifying condition has persisted. The condition is a tachometer count above the expected count while the fan's PWM duty sits at full scale, and it must last for longer than a programmable number of samples. The fan flags stay set until software clears them by writing ones.

Every alarm flag has an enable bit. The interrupt output is driven low while any flag and its enable are both set. Software reads and writes the flag and enable registers through a simple indexed register port, and read data returns combinationally.

Top module: `hwa_alarm_irq`

## Requirements
- R1: After reset, the registers at indices 30h, 31h, 33h and 34h all read 00h and smi_n is high.
- R2: Bit i (i = 0..3) of register 31h updates only on a cycle with smp_vld high. It becomes 1 when voltage reading i is strictly above its high limit or strictly below its low limit, and 0 otherwise. Between strobes the bit holds its value, whatever the readings do.
- R3: Bit 4 of register 31h (the temperature flag) becomes 1 on a strobe with the reading strictly above temp_hi. It becomes 0 on a strobe with the reading strictly below temp_hyst and not above temp_hi. On any other strobe it holds.
- R4: A fan sample qualifies when its count is strictly greater than its expected count and its duty equals FFh. The fan's bit f in register 34h sets on the (fault_time+1)-th consecutive qualifying strobe. A non-qualifying strobe restarts the run, and a bit that is already set stays set.
- R5: Writing 1 to bit f of register 34h clears it when the last strobe for fan f did not complete a qualified run. Writing 0 leaves the bit unchanged.
- R6: A write of 1 to a fan bit of register 34h, made while that fan's most recent strobe still completed a qualified run, leaves the bit set.
- R7: Register 30h holds a 5-bit enable in bits 4..0 (bit i for voltage i, bit 4 for temperature). Register 33h holds one enable per fan in bits 1..0. All other bits of registers 30h, 31h, 33h and 34h read 0 and ignore writes. Register 31h ignores writes, and an unmapped index reads 00h.
- R8: smi_n is a register. It is low in the cycle after any status bit and its matching enable bit are both 1, and high in the cycle after no such pair remains. A status bit whose enable is 0 does not affect smi_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld | input | 1 | Sample-valid strobe for all readings |
| volt_rd | input | 32 | Voltage readings, channel i in bits 8i+7..8i |
| volt_hi | input | 32 | Voltage high limits, same packing |
| volt_lo | input | 32 | Voltage low limits, same packing |
| temp_rd | input | 8 | Temperature reading |
| temp_hi | input | 8 | Temperature high limit |
| temp_hyst | input | 8 | Temperature clear threshold |
| fan_cnt | input | 24 | Measured fan counts, fan f in bits 12f+11..12f |
| fan_exp | input | 24 | Expected fan counts, same packing |
| pwm_duty | input | 16 | PWM duty per fan, fan f in bits 8f+7..8f |
| fault_time | input | 8 | Extra consecutive qualifying samples needed before a fan fault |
| reg_addr | input | 8 | Register index |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| smi_n | output | 1 | Active-low interrupt |

## Verification
Every voltage channel is swept over all 256 reading values, each channel with different limits and offsets. This separates the strict comparisons from inclusive ones at both edges of the window. The temperature reading ramps up and then down across the full range, which shows whether the flag holds in the band between the two thresholds and clears only below the lower one. For every fault time from 0 to 3, fan runs of increasing length are applied and broken either by a count equal to the expected count or by a duty one step below full scale. These runs expose off-by-one errors in the run length and confirm that the two fans are independent. The clear writes are placed both inside and outside a qualified run. The interrupt output is watched cycle by cycle as the enables and the status bits change.

// File: rtl/hwa_pkg.sv
`timescale 1ns/1ps
package hwa_pkg;
  localparam int unsigned DATA_W = 8;
  // register indices; the fan pair keeps its fixed placement
  localparam logic [7:0] IDX_VT_EN   = 8'h30;
  localparam logic [7:0] IDX_VT_STS  = 8'h31;
  localparam logic [7:0] IDX_FAN_EN  = 8'h33;
  localparam logic [7:0] IDX_FAN_STS = 8'h34;
  localparam logic [DATA_W-1:0] FULL_DUTY = {DATA_W{1'b1}};
endpackage

// File: rtl/hwa_window_cmp.sv
`timescale 1ns/1ps
module hwa_window_cmp #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_vld,
  input  logic [W-1:0] rd,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  output logic         flag_q
);
  logic out_of_win;

  always_comb begin
    out_of_win = (rd > hi) || (rd < lo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (smp_vld) flag_q <= out_of_win;
  end
endmodule

// File: rtl/hwa_hyst_cmp.sv
`timescale 1ns/1ps
module hwa_hyst_cmp #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_vld,
  input  logic [W-1:0] rd,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] hyst,
  output logic         flag_q
);
  logic flag_d;

  always_comb begin
    if (rd > hi)        flag_d = 1'b1;
    else if (rd < hyst) flag_d = 1'b0;
    else                flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (smp_vld) flag_q <= flag_d;
  end
endmodule

// File: rtl/hwa_fan_qual.sv
`timescale 1ns/1ps
module hwa_fan_qual
  import hwa_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned TMR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  exp_cnt,
  input  logic [DATA_W-1:0] duty,
  input  logic [TMR_W-1:0]  fault_time,
  output logic              flt_q
);
  logic             cond;
  logic             tmr_done;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             flt_d;

  always_comb begin
    cond     = (cnt > exp_cnt) && (duty == FULL_DUTY);
    tmr_done = (tmr_q >= fault_time);
    if (!cond)         tmr_d = '0;
    else if (tmr_done) tmr_d = tmr_q;
    else               tmr_d = tmr_q + 1'b1;
    flt_d = cond && tmr_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      flt_q <= 1'b0;
    end else if (smp_vld) begin
      tmr_q <= tmr_d;
      flt_q <= flt_d;
    end
  end
endmodule

// File: rtl/hwa_alarm_irq.sv
`timescale 1ns/1ps
module hwa_alarm_irq
  import hwa_pkg::*;
#(
  parameter int unsigned NUM_VOLT = 4,
  parameter int unsigned NUM_FAN  = 2,
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned TMR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_vld,
  input  logic [NUM_VOLT*DATA_W-1:0] volt_rd,
  input  logic [NUM_VOLT*DATA_W-1:0] volt_hi,
  input  logic [NUM_VOLT*DATA_W-1:0] volt_lo,
  input  logic [DATA_W-1:0]          temp_rd,
  input  logic [DATA_W-1:0]          temp_hi,
  input  logic [DATA_W-1:0]          temp_hyst,
  input  logic [NUM_FAN*CNT_W-1:0]   fan_cnt,
  input  logic [NUM_FAN*CNT_W-1:0]   fan_exp,
  input  logic [NUM_FAN*DATA_W-1:0]  pwm_duty,
  input  logic [TMR_W-1:0]           fault_time,
  input  logic [7:0]                 reg_addr,
  input  logic                       reg_wr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  output logic                       smi_n
);
  localparam int unsigned NUM_VT = NUM_VOLT + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  // voltage and temperature flags
  logic [NUM_VT-1:0] vt_sts;

  for (genvar i = 0; i < NUM_VOLT; i++) begin : g_volt
    hwa_window_cmp #(.W(DATA_W)) cmp_i (
      .clk     (clk),
      .rst_n   (rst_sn),
      .smp_vld (smp_vld),
      .rd      (volt_rd[i*DATA_W +: DATA_W]),
      .hi      (volt_hi[i*DATA_W +: DATA_W]),
      .lo      (volt_lo[i*DATA_W +: DATA_W]),
      .flag_q  (vt_sts[i])
    );
  end

  hwa_hyst_cmp #(.W(DATA_W)) temp_i (
    .clk     (clk),
    .rst_n   (rst_sn),
    .smp_vld (smp_vld),
    .rd      (temp_rd),
    .hi      (temp_hi),
    .hyst    (temp_hyst),
    .flag_q  (vt_sts[NUM_VOLT])
  );

  // fan qualification
  logic [NUM_FAN-1:0] fan_flt;

  for (genvar f = 0; f < NUM_FAN; f++) begin : g_fan
    hwa_fan_qual #(.CNT_W(CNT_W), .TMR_W(TMR_W)) qual_i (
      .clk        (clk),
      .rst_n      (rst_sn),
      .smp_vld    (smp_vld),
      .cnt        (fan_cnt[f*CNT_W +: CNT_W]),
      .exp_cnt    (fan_exp[f*CNT_W +: CNT_W]),
      .duty       (pwm_duty[f*DATA_W +: DATA_W]),
      .fault_time (fault_time),
      .flt_q      (fan_flt[f])
    );
  end

  // register file next state
  logic [NUM_VT-1:0]  vt_en,   vt_en_d;
  logic [NUM_FAN-1:0] fan_en,  fan_en_d;
  logic [NUM_FAN-1:0] fan_sts, fan_sts_d;
  logic [NUM_FAN-1:0] fan_clr;
  logic               smi_n_d;

  always_comb begin
    vt_en_d  = vt_en;
    fan_en_d = fan_en;
    fan_clr  = '0;
    if (reg_wr) begin
      if (reg_addr == IDX_VT_EN)   vt_en_d  = reg_wdata[NUM_VT-1:0];
      if (reg_addr == IDX_FAN_EN)  fan_en_d = reg_wdata[NUM_FAN-1:0];
      if (reg_addr == IDX_FAN_STS) fan_clr  = reg_wdata[NUM_FAN-1:0];
    end
    // a qualified fault outranks the clear
    fan_sts_d = fan_flt | (fan_sts & ~fan_clr);
    smi_n_d   = ~((|(vt_sts & vt_en)) | (|(fan_sts & fan_en)));
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      vt_en   <= '0;
      fan_en  <= '0;
      fan_sts <= '0;
      smi_n   <= 1'b1;
    end else begin
      vt_en   <= vt_en_d;
      fan_en  <= fan_en_d;
      fan_sts <= fan_sts_d;
      smi_n   <= smi_n_d;
    end
  end

  // read mux
  always_comb begin
    unique case (reg_addr)
      IDX_VT_EN:   reg_rdata = DATA_W'(vt_en);
      IDX_VT_STS:  reg_rdata = DATA_W'(vt_sts);
      IDX_FAN_EN:  reg_rdata = DATA_W'(fan_en);
      IDX_FAN_STS: reg_rdata = DATA_W'(fan_sts);
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/hwa_alarm_irq_chk.sv
`timescale 1ns/1ps
module hwa_alarm_irq_chk
  import hwa_pkg::*;
#(
  parameter int unsigned NUM_VOLT = 4,
  parameter int unsigned NUM_FAN  = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       smp_vld,
  input logic [NUM_VOLT*DATA_W-1:0] volt_rd,
  input logic [NUM_VOLT*DATA_W-1:0] volt_hi,
  input logic [NUM_VOLT*DATA_W-1:0] volt_lo,
  input logic [DATA_W-1:0]          temp_rd,
  input logic [DATA_W-1:0]          temp_hi,
  input logic [DATA_W-1:0]          temp_hyst,
  input logic [7:0]                 reg_addr,
  input logic                       reg_wr,
  input logic [DATA_W-1:0]          reg_wdata,
  input logic [DATA_W-1:0]          reg_rdata,
  input logic                       smi_n,
  input logic [NUM_VOLT:0]          vt_sts,
  input logic [NUM_VOLT:0]          vt_en,
  input logic [NUM_FAN-1:0]         fan_sts,
  input logic [NUM_FAN-1:0]         fan_en
);
  for (genvar i = 0; i < NUM_VOLT; i++) begin : g_v
    AST_VOLT_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld && ((volt_rd[i*DATA_W +: DATA_W] > volt_hi[i*DATA_W +: DATA_W]) ||
                  (volt_rd[i*DATA_W +: DATA_W] < volt_lo[i*DATA_W +: DATA_W]))
      |=> vt_sts[i]); // R2
    AST_VOLT_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld && !((volt_rd[i*DATA_W +: DATA_W] > volt_hi[i*DATA_W +: DATA_W]) ||
                   (volt_rd[i*DATA_W +: DATA_W] < volt_lo[i*DATA_W +: DATA_W]))
      |=> !vt_sts[i]); // R2
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(vt_sts)); // R2

  AST_TEMP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && (temp_rd > temp_hi) |=> vt_sts[NUM_VOLT]); // R3

  AST_TEMP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && (temp_rd < temp_hyst) && !(temp_rd > temp_hi) |=> !vt_sts[NUM_VOLT]); // R3

  for (genvar f = 0; f < NUM_FAN; f++) begin : g_f
    AST_FAN_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && (reg_addr == IDX_FAN_STS) && !reg_wdata[f] && fan_sts[f]
      |=> fan_sts[f]); // R5
  end

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == IDX_FAN_EN) || (reg_addr == IDX_FAN_STS)
    |-> (reg_rdata >> NUM_FAN) == '0); // R7

  AST_SMI_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> smi_n == !$past((|(vt_sts & vt_en)) || (|(fan_sts & fan_en)))); // R8
endmodule

bind hwa_alarm_irq hwa_alarm_irq_chk #(.NUM_VOLT(NUM_VOLT), .NUM_FAN(NUM_FAN)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sn),
  .smp_vld   (smp_vld),
  .volt_rd   (volt_rd),
  .volt_hi   (volt_hi),
  .volt_lo   (volt_lo),
  .temp_rd   (temp_rd),
  .temp_hi   (temp_hi),
  .temp_hyst (temp_hyst),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .smi_n     (smi_n),
  .vt_sts    (vt_sts),
  .vt_en     (vt_en),
  .fan_sts   (fan_sts),
  .fan_en    (fan_en)
);

// File: tb/hwa_alarm_irq_tb_top.sv
`timescale 1ns/1ps
module hwa_alarm_irq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  localparam int NF = 2;
  localparam int CW = 12;
  localparam int TW = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              smp_vld;
  logic [NV*8-1:0]   volt_rd, volt_hi, volt_lo;
  logic [7:0]        temp_rd, temp_hi, temp_hyst;
  logic [NF*CW-1:0]  fan_cnt, fan_exp;
  logic [NF*8-1:0]   pwm_duty;
  logic [TW-1:0]     fault_time;
  logic [7:0]        reg_addr;
  logic              reg_wr;
  logic [7:0]        reg_wdata;
  logic [7:0]        reg_rdata;
  logic              smi_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwa_alarm_irq dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
    .volt_rd(volt_rd), .volt_hi(volt_hi), .volt_lo(volt_lo),
    .temp_rd(temp_rd), .temp_hi(temp_hi), .temp_hyst(temp_hyst),
    .fan_cnt(fan_cnt), .fan_exp(fan_exp), .pwm_duty(pwm_duty),
    .fault_time(fault_time), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smi_n(smi_n)
  );

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // all tasks are entered just after a falling edge
  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic smp();
    smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  // kind 0: qualifying; 1: count equals expected; 2: duty one below full
  task automatic set_fan(input int f, input int kind);
    fan_cnt[f*CW +: CW] = (kind == 1) ? 12'd1000 : 12'd1001;
    pwm_duty[f*8 +: 8]  = (kind == 2) ? 8'hFE : 8'hFF;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [7:0] last;
    logic       tflag;
    rst_n = 1'b0; smp_vld = 1'b0; reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
    volt_rd = '0; volt_hi = '0; volt_lo = '0;
    temp_rd = 8'd0; temp_hi = 8'd100; temp_hyst = 8'd80;
    fan_exp = {12'd1000, 12'd1000}; fan_cnt = {12'd900, 12'd900}; pwm_duty = '0;
    fault_time = '0;
    for (int i = 0; i < NV; i++) begin
      volt_lo[i*8 +: 8] = 8'(40 + i*10);
      volt_hi[i*8 +: 8] = 8'(200 - i*10);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(8'h30, d); chk("R1 idx30", d, 8'h00);
    rd(8'h31, d); chk("R1 idx31", d, 8'h00);
    rd(8'h33, d); chk("R1 idx33", d, 8'h00);
    rd(8'h34, d); chk("R1 idx34", d, 8'h00);
    chk("R1 smi_n", smi_n, 1'b1);

    // R7 register widths and reserved bits
    wr(8'h33, 8'hFF); rd(8'h33, d); chk("R7 fan enable", d, 8'h03);
    wr(8'h34, 8'hFF); rd(8'h34, d); chk("R7 fan status", d, 8'h00);
    wr(8'h30, 8'hFF); rd(8'h30, d); chk("R7 vt enable", d, 8'h1F);
    wr(8'h31, 8'hFF); rd(8'h31, d); chk("R7 vt status write", d, 8'h00);
    rd(8'h3F, d); chk("R7 unmapped", d, 8'h00);
    wr(8'h30, 8'h00); wr(8'h33, 8'h00);
    rd(8'h30, d); chk("R7 vt enable clear", d, 8'h00);

    // R2 full sweep of every voltage channel
    for (int v = 0; v < 256; v++) begin
      logic [7:0] e;
      e = 8'h00;
      for (int i = 0; i < NV; i++) begin
        int r;
        r = (v + i*37) % 256;
        volt_rd[i*8 +: 8] = 8'(r);
        e[i] = (r > 200 - i*10) || (r < 40 + i*10);
      end
      smp();
      rd(8'h31, d);
      chk($sformatf("R2 sweep v=%0d", v), d, e);
      last = e;
    end
    volt_rd = '1;
    repeat (2) @(negedge clk);
    rd(8'h31, d); chk("R2 hold without strobe", d, last);
    volt_rd = {4{8'd100}};
    smp();
    rd(8'h31, d); chk("R2 all in window", d, 8'h00);

    // R3 temperature ramp up then down
    tflag = 1'b0;
    for (int s = 0; s < 172; s++) begin
      int t;
      t = (s < 86) ? s*3 : (171 - s)*3;
      temp_rd = 8'(t);
      if (t > 100)     tflag = 1'b1;
      else if (t < 80) tflag = 1'b0;
      smp();
      rd(8'h31, d);
      chk($sformatf("R3 temp t=%0d", t), d, {3'b000, tflag, 4'h0});
    end

    // R4 R5 R6 fan qualification and clearing
    for (int ft = 0; ft < 4; ft++) begin
      fault_time = TW'(ft);
      for (int f = 0; f < NF; f++) begin
        int  run;
        logic sm;
        run = 0;
        sm  = 1'b0;
        fan_cnt[(1-f)*CW +: CW] = 12'd900;
        pwm_duty[(1-f)*8 +: 8]  = 8'hFF;
        for (int len = 1; len <= ft + 2; len++) begin
          for (int k = 0; k < len; k++) begin
            set_fan(f, 0);
            smp();
            run++;
            if (run >= ft + 1) sm = 1'b1;
            @(negedge clk);
            rd(8'h34, d);
            chk($sformatf("R4 ft=%0d fan=%0d len=%0d k=%0d", ft, f, len, k), d, 8'(sm) << f);
          end
          if (len == ft + 2) begin
            wr(8'h34, 8'h00);
            rd(8'h34, d); chk("R5 zero write keeps bit", d, 8'(1) << f);
            wr(8'h34, 8'(1) << f);
            rd(8'h34, d); chk("R6 clear during fault", d, 8'(1) << f);
          end
          set_fan(f, 1 + (len % 2));
          smp();
          run = 0;
          @(negedge clk);
          rd(8'h34, d);
          chk($sformatf("R4 sticky ft=%0d fan=%0d len=%0d", ft, f, len), d, 8'(sm) << f);
          wr(8'h34, 8'(1) << f);
          sm = 1'b0;
          rd(8'h34, d);
          chk($sformatf("R5 clear ft=%0d fan=%0d len=%0d", ft, f, len), d, 8'h00);
        end
        fan_cnt[f*CW +: CW] = 12'd900;
      end
    end

    // R8 interrupt output
    volt_rd[7:0] = 8'd0;
    smp();
    repeat (2) @(negedge clk);
    chk("R8 masked voltage", smi_n, 1'b1);
    wr(8'h30, 8'h01);
    chk("R8 latency before", smi_n, 1'b1);
    @(negedge clk);
    chk("R8 enabled voltage", smi_n, 1'b0);
    wr(8'h30, 8'h1E);
    chk("R8 still low", smi_n, 1'b0);
    @(negedge clk);
    chk("R8 disabled voltage", smi_n, 1'b1);
    fault_time = '0;
    set_fan(1, 0);
    smp();
    repeat (2) @(negedge clk);
    chk("R8 masked fan", smi_n, 1'b1);
    wr(8'h33, 8'h02);
    @(negedge clk);
    chk("R8 enabled fan", smi_n, 1'b0);
    set_fan(1, 1);
    smp();
    wr(8'h34, 8'h02);
    chk("R8 release latency", smi_n, 1'b0);
    @(negedge clk);
    chk("R8 released", smi_n, 1'b1);

    finish_run();
  end
endmodule